// File: doc/BRIEF.md
# Temporal Interval Relation Authorization Checker

This block decides whether a memory access request satisfies a temporal policy. It receives three half-open intervals: the present time unit, the subject's time attribute and the object's time attribute. The present time is given as a single clock value `tnow` and is widened internally to the unit interval [tnow, tnow+1). The block classifies the relation between each of three interval pairs into one of thirteen interval-algebra relations. Each result becomes a one-hot 16-bit code, which is tested against one 16-bit slice of a 48-bit policy word.

The request is granted only if every pair's relation appears in its slice and all intervals are well formed. The request is taken on a `valid` strobe. One clock later the block presents the grant, a per-pair hit vector and a one-cycle `done` pulse. It sits beside the page-translation path and gives the initial authorization verdict for a page or kernel object. Expiration-time computation and policy storage are handled elsewhere.

Top module: `tir_auth_check`

## Requirements
- R1: While `rst_n` is low and after it is released, `grant`, `pair_hit` and `done` are 0 until the first accepted request.
- R2: For intervals x=[xs,xe) and y=[ys,ye), compared as unsigned values, the relation code has exactly one bit set, at this position: 12 BEFORE (xe<ys), 6 MEETS (xe==ys), 11 AFTER (xs>ye), 5 MET_BY (xs==ye), 0 EQUALS (xs==ys and xe==ye), 4 STARTS (xs==ys, xe<ye), 3 STARTED_BY (xs==ys, xe>ye), 2 FINISHES (xe==ye, xs>ys), 1 FINISHED_BY (xe==ye, xs<ys), 10 DURING (xs>ys, xe<ye), 9 INCLUDES (xs<ys, xe>ye), 8 OVERLAPS (xs<ys, ys<xe<ye), 7 OVERLAPPED_BY (the remaining case).
- R3: The policy slices are laid out as follows. `policy[47:32]` applies to (now, object) and drives `pair_hit[2]`. `policy[31:16]` applies to (now, subject) and drives `pair_hit[1]`. `policy[15:0]` applies to (subject, object) and drives `pair_hit[0]`. A pair hits when its code shares a set bit with its slice.
- R4: `grant` is 1 exactly when all three pairs hit and the request is well formed.
- R5: A policy word of all zeros never grants, and it gives `pair_hit` = 0.
- R6: Policy bits 13 to 15 of each slice have no effect, and a slice holding only those bits never hits.
- R7: If the subject or object interval has end <= start, the request is malformed, and the result is `grant`=0 and `pair_hit`=0 even when the policy allows every relation.
- R8: Results appear in the cycle after `valid` is sampled high, together with a one-cycle `done` pulse. While `valid` is low, `grant` and `pair_hit` keep their values and `done` is 0.
- R9: The present interval's end is tnow+1 computed without wrap-around. When tnow is the largest clock value, the present interval is still well formed and is classified by its true endpoints.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Request strobe; inputs are sampled when high |
| tnow | input | TW | Reference clock value, start of present unit interval |
| subj_start | input | TW | Subject interval closed start |
| subj_end | input | TW | Subject interval open end |
| obj_start | input | TW | Object interval closed start |
| obj_end | input | TW | Object interval open end |
| policy | input | 48 | Three 16-bit allowed-relation masks |
| grant | output | 1 | Registered access verdict |
| pair_hit | output | 3 | Registered per-pair match ({now-obj, now-subj, subj-obj}) |
| done | output | 1 | One-cycle pulse marking a fresh result |

## Verification
Two functions can fall in the same cycle: the malformed-interval override and a policy that would otherwise match every pair. To provoke this, the bench presents an inverted subject or object interval under a policy with all thirteen relation bits set in every slice. The expected result is `grant`=0 and `pair_hit`=0, so the override must win over the full match. A second collision is a request arriving in the same cycle as reserved-only slices. It is judged by requiring that the affected pair reports no hit while the other pairs hit as their exact codes predict.

// File: rtl/tir_pkg.sv
package tir_pkg;

    localparam int REL_W    = 16;
    localparam int NUM_REL  = 13;
    localparam int NUM_PAIR = 3;
    localparam int POL_W    = REL_W * NUM_PAIR;

    // Bit positions of each relation inside a 16-bit code or policy slice.
    localparam int B_EQ   = 0;
    localparam int B_FI   = 1;
    localparam int B_F    = 2;
    localparam int B_SI   = 3;
    localparam int B_S    = 4;
    localparam int B_MI   = 5;
    localparam int B_M    = 6;
    localparam int B_OI   = 7;
    localparam int B_O    = 8;
    localparam int B_DI   = 9;
    localparam int B_D    = 10;
    localparam int B_AFT  = 11;
    localparam int B_BEF  = 12;

    // Only the thirteen defined relation bits may ever take part in a match.
    localparam logic [REL_W-1:0] REL_KEEP = REL_W'((1 << NUM_REL) - 1);

    // Pair slot indices; slot k uses policy[16k+15:16k].
    localparam int P_SO = 0;
    localparam int P_TS = 1;
    localparam int P_TO = 2;

    typedef struct packed {
        logic                grant;
        logic [NUM_PAIR-1:0] hit;
        logic                done;
    } res_t;

    localparam res_t RES_RST = '{grant: 1'b0, hit: '0, done: 1'b0};

endpackage

// File: rtl/tir_rel_classify.sv
module tir_rel_classify
    import tir_pkg::*;
#(
    parameter int EW = 33
) (
    input  logic [EW-1:0]    xs,
    input  logic [EW-1:0]    xe,
    input  logic [EW-1:0]    ys,
    input  logic [EW-1:0]    ye,
    output logic [REL_W-1:0] code
);

    logic s_lt, s_eq, e_lt, e_eq;
    logic x_before, x_meets, x_after, x_metby;

    always_comb begin
        s_lt     = xs < ys;
        s_eq     = xs == ys;
        e_lt     = xe < ye;
        e_eq     = xe == ye;
        x_before = xe < ys;
        x_meets  = xe == ys;
        x_after  = xs > ye;
        x_metby  = xs == ye;
    end

    always_comb begin
        code = '0;
        if (x_before)                 code[B_BEF] = 1'b1;
        else if (x_meets)             code[B_M]   = 1'b1;
        else if (x_after)             code[B_AFT] = 1'b1;
        else if (x_metby)             code[B_MI]  = 1'b1;
        else if (s_eq && e_eq)        code[B_EQ]  = 1'b1;
        else if (s_eq)                code[e_lt ? B_S : B_SI] = 1'b1;
        else if (e_eq)                code[s_lt ? B_FI : B_F] = 1'b1;
        else if (!s_lt && e_lt)       code[B_D]   = 1'b1;
        else if (s_lt && !e_lt)       code[B_DI]  = 1'b1;
        else if (s_lt)                code[B_O]   = 1'b1;
        else                          code[B_OI]  = 1'b1;
    end

endmodule

// File: rtl/tir_pair_match.sv
module tir_pair_match
    import tir_pkg::*;
(
    input  logic [REL_W-1:0] code,
    input  logic [REL_W-1:0] allow,
    output logic             hit
);

    logic [REL_W-1:0] allow_kept;

    always_comb begin
        allow_kept = allow & REL_KEEP;
        hit        = |(code & allow_kept);
    end

endmodule

// File: rtl/tir_auth_check.sv
module tir_auth_check
    import tir_pkg::*;
#(
    parameter int TW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [TW-1:0]    tnow,
    input  logic [TW-1:0]    subj_start,
    input  logic [TW-1:0]    subj_end,
    input  logic [TW-1:0]    obj_start,
    input  logic [TW-1:0]    obj_end,
    input  logic [POL_W-1:0] policy,
    output logic             grant,
    output logic [2:0]       pair_hit,
    output logic             done
);

    localparam int EW = TW + 1;

    logic [EW-1:0] now_s, now_e, sub_s, sub_e, obj_s, obj_e;
    logic [EW-1:0] xs_a [NUM_PAIR];
    logic [EW-1:0] xe_a [NUM_PAIR];
    logic [EW-1:0] ys_a [NUM_PAIR];
    logic [EW-1:0] ye_a [NUM_PAIR];
    logic [REL_W-1:0] code_a [NUM_PAIR];
    logic [NUM_PAIR-1:0] hit_raw;
    logic malformed;
    res_t res_d, res_q;

    // Widen by one bit so tnow+1 never wraps.
    always_comb begin
        now_s = {1'b0, tnow};
        now_e = {1'b0, tnow} + EW'(1);
        sub_s = {1'b0, subj_start};
        sub_e = {1'b0, subj_end};
        obj_s = {1'b0, obj_start};
        obj_e = {1'b0, obj_end};
        malformed = (sub_e <= sub_s) || (obj_e <= obj_s);

        xs_a[P_SO] = sub_s; xe_a[P_SO] = sub_e; ys_a[P_SO] = obj_s; ye_a[P_SO] = obj_e;
        xs_a[P_TS] = now_s; xe_a[P_TS] = now_e; ys_a[P_TS] = sub_s; ye_a[P_TS] = sub_e;
        xs_a[P_TO] = now_s; xe_a[P_TO] = now_e; ys_a[P_TO] = obj_s; ye_a[P_TO] = obj_e;
    end

    for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
        tir_rel_classify #(.EW(EW)) u_cls (
            .xs   (xs_a[k]),
            .xe   (xe_a[k]),
            .ys   (ys_a[k]),
            .ye   (ye_a[k]),
            .code (code_a[k])
        );
        tir_pair_match u_mat (
            .code  (code_a[k]),
            .allow (policy[k*REL_W +: REL_W]),
            .hit   (hit_raw[k])
        );
    end

    always_comb begin
        res_d      = res_q;
        res_d.done = 1'b0;
        if (valid) begin
            res_d.done  = 1'b1;
            res_d.hit   = malformed ? '0 : hit_raw;
            res_d.grant = !malformed && (&hit_raw);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= RES_RST;
        else        res_q <= res_d;
    end

    assign grant    = res_q.grant;
    assign pair_hit = res_q.hit;
    assign done     = res_q.done;

    // R2
    so_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !malformed |-> $countones(code_a[P_SO]) == 1);
    // R2
    to_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(code_a[P_TO]) == 1 && $countones(code_a[P_TS]) == 1);
    // R6
    no_reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_a[P_SO][15:13] == 3'b0 && code_a[P_TS][15:13] == 3'b0 && code_a[P_TO][15:13] == 3'b0);
    // R4
    grant_all_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> pair_hit == 3'b111);
    // R5
    zero_policy_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid && policy == '0 |=> !grant && pair_hit == 3'b000);
    // R7
    malformed_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid && (subj_end <= subj_start || obj_end <= obj_start) |=> !grant && pair_hit == 3'b000);
    // R8
    done_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> done);
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> !done && $stable(grant) && $stable(pair_hit));

endmodule

// File: tb/tir_auth_check_bench.sv
module tir_auth_check_bench;

    localparam int TW   = 3;
    localparam int TMAX = (1 << TW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic valid = 1'b0;
    logic [TW-1:0] tnow = '0, subj_start = '0, subj_end = '0, obj_start = '0, obj_end = '0;
    logic [47:0] policy = '0;
    logic grant;
    logic [2:0] pair_hit;
    logic done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    tir_auth_check #(.TW(TW)) u_tir_auth_check (
        .clk(clk), .rst_n(rst_n), .valid(valid), .tnow(tnow),
        .subj_start(subj_start), .subj_end(subj_end),
        .obj_start(obj_start), .obj_end(obj_end),
        .policy(policy), .grant(grant), .pair_hit(pair_hit), .done(done)
    );

    // Relation index from a sign table of four endpoint comparisons.
    function automatic int rel_idx(int xs, int xe, int ys, int ye);
        int ss, ee;
        if (xe < ys)  return 12;
        if (xe == ys) return 6;
        if (xs > ye)  return 11;
        if (xs == ye) return 5;
        ss = (xs > ys) - (xs < ys);
        ee = (xe > ye) - (xe < ye);
        case ({ss, ee})
            {0, 0}:   return 0;
            {0, -1}:  return 4;
            {0, 1}:   return 3;
            {1, 0}:   return 2;
            {-1, 0}:  return 1;
            {1, -1}:  return 10;
            {-1, 1}:  return 9;
            {-1, -1}: return 8;
            default:  return 7;
        endcase
    endfunction

    task automatic check(string req, logic [2:0] exp_hit, logic exp_grant);
        n_chk++;
        if (pair_hit !== exp_hit || grant !== exp_grant || done !== 1'b1) begin
            n_bad++;
            $display("FAIL %s: hit=%b grant=%b done=%b expected hit=%b grant=%b done=1",
                     req, pair_hit, grant, done, exp_hit, exp_grant);
        end
    endtask

    task automatic apply(int t, int a, int b, int c, int d, logic [47:0] pol);
        @(negedge clk);
        tnow = TW'(t); subj_start = TW'(a); subj_end = TW'(b);
        obj_start = TW'(c); obj_end = TW'(d); policy = pol;
        valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: hit=%b grant=%b expected completion", pair_hit, grant);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] cto, cts, cso;
        logic [15:0] full;
        int idx;
        full = 16'h1FFF;
        idx = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        n_chk++;
        if (grant !== 1'b0 || pair_hit !== 3'b0 || done !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: hit=%b grant=%b done=%b expected 000/0/0", pair_hit, grant, done);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (grant !== 1'b0 || pair_hit !== 3'b0 || done !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: hit=%b grant=%b done=%b after release expected 000/0/0", pair_hit, grant, done);
        end

        // Worked vector: now=[5,6), subject=[2,6), object=[4,7)
        apply(5, 2, 6, 4, 7, {16'h0414, 16'h0404, 16'h0302});
        check("R3 worked vector", 3'b111, 1'b1);

        // Exhaustive sweep over well-formed intervals (R2 R3 R4 R6 R9)
        for (int t = 0; t <= TMAX; t++)
          for (int a = 0; a <= TMAX; a++)
            for (int b = a + 1; b <= TMAX; b++)
              for (int c = 0; c <= TMAX; c++)
                for (int d = c + 1; d <= TMAX; d++) begin
                    cto = 16'(1) << rel_idx(t, t + 1, c, d);
                    cts = 16'(1) << rel_idx(t, t + 1, a, b);
                    cso = 16'(1) << rel_idx(a, b, c, d);
                    apply(t, a, b, c, d, {cto, cts, cso});
                    check((t == TMAX) ? "R9 top clock value" : "R2 exact code", 3'b111, 1'b1);
                    apply(t, a, b, c, d, {full ^ cto, full ^ cts, full ^ cso});
                    check("R2 complement code", 3'b000, 1'b0);
                    case (idx % 3)
                        0: begin
                            apply(t, a, b, c, d, {16'hE000 | cto, 16'hE000 | cts, 16'hE000});
                            check("R6 reserved-only slice", 3'b110, 1'b0);
                        end
                        1: begin
                            apply(t, a, b, c, d, {cto, full ^ cts, cso});
                            check("R3 slice position", 3'b101, 1'b0);
                        end
                        default: begin
                            apply(t, a, b, c, d, {full ^ cto, cts, cso | 16'hE000});
                            check("R4 partial match", 3'b011, 1'b0);
                        end
                    endcase
                    idx++;
                end

        // R5 zero policy
        apply(3, 1, 5, 2, 6, 48'h0);
        check("R5 zero policy", 3'b000, 1'b0);

        // R7 malformed under full policy (collision case)
        apply(3, 5, 5, 2, 6, {3{16'h1FFF}});
        check("R7 empty subject", 3'b000, 1'b0);
        apply(3, 1, 5, 6, 2, {3{16'h1FFF}});
        check("R7 inverted object", 3'b000, 1'b0);

        // R8 hold while idle, done drops
        apply(4, 0, 7, 0, 7, {3{16'h1FFF}});
        check("R8 fresh result", 3'b111, 1'b1);
        policy = 48'h0;
        @(negedge clk);
        n_chk++;
        if (done !== 1'b0 || grant !== 1'b1 || pair_hit !== 3'b111) begin
            n_bad++;
            $display("FAIL R8: hit=%b grant=%b done=%b expected 111/1/0 held", pair_hit, grant, done);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule